// File: doc/BRIEF.md
# Dual Edge-Qualified Four-Bit Counter

This block contains two identical four-bit counters that run independently. Each counter has a count-trigger input, a gate input and a clear input. Either a rising edge on the trigger input while the gate is high, or a falling edge on the gate input while the trigger is low, advances the count. The two inputs can therefore swap roles. An elaboration parameter chooses BCD (decade) or plain binary counting for both counters. Wiring one counter's most significant output into the next counter's gate, with that counter's trigger tied low, forms a ripple cascade.

All logic runs on one free-running system clock. The trigger and gate inputs pass through a two-stage synchronizer, and their edges are found by comparing each new sample with the one before it. A clear input zeroes its counter asynchronously and keeps it at zero until the synchronized release.

Top module: `dual_trig_counter`

## Requirements
- R1: While `rst_ni` is low, both counters read zero on `q_o`.
- R2: A rising trigger edge with the gate high adds one. If the new trigger level is first sampled at system clock rising edge n, the new count appears on `q_o` just after edge n+3.
- R3: A falling gate edge with the trigger low adds one, with the same latency as R2.
- R4: The count does not change on a falling trigger edge, on a rising gate edge, on a rising trigger edge with the gate low, or on a falling gate edge with the trigger high.
- R5: A rising trigger edge and a falling gate edge sampled at the same system edge add exactly one. No counter advances on two consecutive system cycles.
- R6: A high level on a clear input zeroes that counter at once, with no clock edge needed, and holds it at zero while the clear stays high. The counter also stays at zero through the second system rising edge after the clear is sampled low.
- R7: With `DECADE`=1 the counter runs 0..9 and wraps from 9 to 0. The count never exceeds 9.
- R8: With `DECADE`=0 the counter runs 0..15 and wraps from 15 to 0.
- R9: Channel c is read on `q_o[4c+3:4c]`, with bit 4c as the least significant bit. Activity on one channel never changes the other channel.
- R10: If channel 1's gate is driven from `q_o[3]` and its trigger is held low, channel 1 advances once each time `q_o[3]` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_CH | Count-trigger input, one bit per channel |
| gate_i | input | NUM_CH | Gate input, one bit per channel |
| clr_i | input | NUM_CH | Active-high clear, one bit per channel |
| q_o | output | 4*NUM_CH | Counter values, four bits per channel |

## Verification
The assertions assume that the trigger and gate inputs change no more than once per system cycle, so the synchronizers pass every level. They also assume that a clear pulse covers at least one system edge. The stimulus changes each input only on the falling system clock edge and holds each level for several cycles, so every edge is sampled cleanly. The most delicate cases are a trigger rising in the same cycle as the gate falling, and the ripple gate that the counter's own output feeds back. A per-cycle behavioural model in the bench shadows both cases.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int unsigned CntW = 4;
  typedef logic [CntW-1:0] cnt_t;

  function automatic cnt_t cnt_advance(cnt_t cur, logic decade);
    if (decade && (cur >= cnt_t'(9))) return '0;
    return cur + cnt_t'(1);
  endfunction
endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned Last = STAGES - 1;
  logic [STAGES-1:0] stg_q, stg_d;

  always_comb stg_d = {stg_q[Last-1:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[Last];
endmodule

// File: rtl/dtc_clr_sync.sv
module dtc_clr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic hold_o
);
  localparam int unsigned Last = STAGES - 1;
  logic [STAGES-1:0] stg_q, stg_d;

  always_comb stg_d = {stg_q[Last-1:0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)    stg_q <= '1;
    else if (clr_i) stg_q <= '1;
    else            stg_q <= stg_d;
  end

  assign hold_o = stg_q[Last];
endmodule

// File: rtl/dtc_trig.sv
module dtc_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_s_i,
  input  logic gate_s_i,
  output logic inc_o
);
  logic trig_prev_q, gate_prev_q, inc_q;
  logic trig_rise, gate_fall, inc_d;

  always_comb begin
    trig_rise = trig_s_i & ~trig_prev_q;
    gate_fall = ~gate_s_i & gate_prev_q;
    inc_d     = (trig_rise & gate_prev_q) | (gate_fall & ~trig_prev_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_prev_q <= 1'b0;
      gate_prev_q <= 1'b0;
      inc_q       <= 1'b0;
    end else begin
      trig_prev_q <= trig_s_i;
      gate_prev_q <= gate_s_i;
      inc_q       <= inc_d;
    end
  end

  assign inc_o = inc_q;

  p_single_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_q |=> !inc_q)
    else $error("two increments in consecutive cycles");

  p_no_trigger_no_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_s_i == trig_prev_q && gate_s_i == gate_prev_q) |=> !inc_q)
    else $error("increment without any input edge");
endmodule

// File: rtl/dtc_cell.sv
module dtc_cell
  import dtc_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output cnt_t cnt_o
);
  cnt_t cnt_q, cnt_d;

  always_comb cnt_d = inc_i ? cnt_advance(cnt_q, DECADE) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_clear_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (cnt_q == '0))
    else $error("count nonzero while clear held");

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> (cnt_q == $past(cnt_q) || cnt_q == '0))
    else $error("count moved without increment");

  if (DECADE) begin : g_dec_chk
    p_decade_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= cnt_t'(9))
      else $error("decade count out of range");
  end
endmodule

// File: rtl/dual_trig_counter.sv
module dual_trig_counter
  import dtc_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter bit          DECADE      = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CH-1:0]      trig_i,
  input  logic [NUM_CH-1:0]      gate_i,
  input  logic [NUM_CH-1:0]      clr_i,
  output logic [CntW*NUM_CH-1:0] q_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic trig_s, gate_s, hold, inc;
    cnt_t cnt;

    dtc_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(trig_i[c]), .q_o(trig_s));

    dtc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i[c]), .q_o(gate_s));

    dtc_clr_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i[c]), .hold_o(hold));

    dtc_trig u_trig (
      .clk_i(clk_i), .rst_ni(rst_ni), .trig_s_i(trig_s), .gate_s_i(gate_s),
      .inc_o(inc));

    dtc_cell #(.DECADE(DECADE)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(hold), .inc_i(inc), .cnt_o(cnt));

    assign q_o[CntW*c +: CntW] = cnt;
  end
endmodule

// File: tb/test_dual_trig_counter.sv
`timescale 1ns/1ps
module test_dual_trig_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [1:0] drv_trig, drv_gate, drv_clr;
  logic       ripple;
  logic [7:0] q_dec, q_bin;
  logic [1:0] gate_dec, gate_bin;

  assign gate_dec = {ripple ? q_dec[3] : drv_gate[1], drv_gate[0]};
  assign gate_bin = {ripple ? q_bin[3] : drv_gate[1], drv_gate[0]};

  dual_trig_counter #(.NUM_CH(2), .DECADE(1'b1)) i_dual_trig_counter (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(drv_trig), .gate_i(gate_dec),
    .clr_i(drv_clr), .q_o(q_dec));

  dual_trig_counter #(.NUM_CH(2), .DECADE(1'b0)) i_dual_trig_counter_bin (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(drv_trig), .gate_i(gate_bin),
    .clr_i(drv_clr), .q_o(q_bin));

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural model, index [mode][channel]; mode 0 = decade, 1 = binary
  int mdl [2][2];
  bit pend [2][2][3];
  bit p_trig [2][2], p_gate [2][2], clr_h1 [2][2], clr_h2 [2][2];

  initial begin
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++) begin
        mdl[m][c] = 0; p_trig[m][c] = 0; p_gate[m][c] = 0;
        clr_h1[m][c] = 0; clr_h2[m][c] = 0;
        for (int k = 0; k < 3; k++) pend[m][c][k] = 0;
      end
  end

  function automatic int advance(int m, int v);
    if (m == 0) return (v >= 9) ? 0 : v + 1;
    return (v + 1) % 16;
  endfunction

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++) begin
        bit t, g, cl, ev, app;
        t  = drv_trig[c];
        g  = (m == 0) ? gate_dec[c] : gate_bin[c];
        cl = drv_clr[c];
        if (!rst_n) begin
          mdl[m][c] = 0;
          for (int k = 0; k < 3; k++) pend[m][c][k] = 0;
          p_trig[m][c] = 0; p_gate[m][c] = 0; clr_h1[m][c] = 0; clr_h2[m][c] = 0;
        end else begin
          ev  = (t & !p_trig[m][c] & p_gate[m][c]) | (!g & p_gate[m][c] & !p_trig[m][c]);
          app = pend[m][c][2];
          pend[m][c][2] = pend[m][c][1];
          pend[m][c][1] = pend[m][c][0];
          pend[m][c][0] = ev;
          if (cl || clr_h1[m][c] || clr_h2[m][c]) mdl[m][c] = 0;
          else if (app) mdl[m][c] = advance(m, mdl[m][c]);
          clr_h2[m][c] = clr_h1[m][c];
          clr_h1[m][c] = cl;
          p_trig[m][c] = t;
          p_gate[m][c] = g;
        end
      end
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < 2; c++) begin
        chk(cur_req, int'(q_dec[4*c +: 4]), mdl[0][c]);
        chk(cur_req, int'(q_bin[4*c +: 4]), mdl[1][c]);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulse_trig(int c, int n);
    repeat (n) begin
      drv_trig[c] = 1'b1; step(4);
      drv_trig[c] = 1'b0; step(4);
    end
  endtask

  task automatic summary;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; drv_trig = '0; drv_gate = '0; drv_clr = '0; ripple = 1'b0;
    step(3);
    chk("R1", int'(q_dec), 0);
    chk("R1", int'(q_bin), 0);
    rst_n = 1'b1; step(4);

    // R2: trigger rising with gate high, with latency check
    cur_req = "R2";
    drv_gate[0] = 1'b1; step(6);
    pulse_trig(0, 3);
    chk("R2", int'(q_dec[3:0]), 3);
    drv_trig[0] = 1'b1; step(3);
    chk("R2", int'(q_dec[3:0]), 3);
    step(1);
    chk("R2", int'(q_dec[3:0]), 4);
    drv_trig[0] = 1'b0; step(5);

    // R4: non-qualifying edges
    cur_req = "R4";
    drv_trig[0] = 1'b1; step(6);            // qualifying: 5
    drv_gate[0] = 1'b0; step(6);            // gate falls, trigger high
    drv_trig[0] = 1'b0; step(6);            // trigger falls
    drv_trig[0] = 1'b1; step(6);            // trigger rises, gate low
    drv_trig[0] = 1'b0; step(6);
    drv_gate[0] = 1'b1; step(6);            // gate rises
    chk("R4", int'(q_dec[3:0]), 5);
    chk("R4", int'(q_bin[3:0]), 5);

    // R3: gate falling with trigger low
    cur_req = "R3";
    drv_gate[0] = 1'b0; step(6);
    chk("R3", int'(q_dec[3:0]), 6);
    drv_gate[0] = 1'b1; step(6);
    drv_gate[0] = 1'b0; step(6);
    chk("R3", int'(q_bin[3:0]), 7);

    // R5: both qualifying edges in one cycle count once
    cur_req = "R5";
    drv_gate[0] = 1'b1; step(6);
    drv_trig[0] = 1'b1; drv_gate[0] = 1'b0; step(6);
    chk("R5", int'(q_dec[3:0]), 8);
    drv_trig[0] = 1'b0; step(6);

    // R9: channel independence and field position
    cur_req = "R9";
    chk("R9", int'(q_dec[7:4]), 0);
    drv_gate[1] = 1'b1; step(6);
    pulse_trig(1, 2);
    chk("R9", int'(q_dec[7:4]), 2);
    chk("R9", int'(q_dec[3:0]), 8);

    // R7 / R8: wrap points
    cur_req = "R7";
    drv_gate[0] = 1'b1; step(6);
    pulse_trig(0, 2);
    chk("R7", int'(q_dec[3:0]), 0);
    chk("R8", int'(q_bin[3:0]), 10);
    cur_req = "R8";
    pulse_trig(0, 6);
    chk("R8", int'(q_bin[3:0]), 0);
    chk("R7", int'(q_dec[3:0]), 6);

    // R6: asynchronous clear
    cur_req = "R6";
    step(1);
    drv_clr[0] = 1'b1; #1;
    chk("R6", int'(q_dec[3:0]), 0);
    chk("R6", int'(q_bin[3:0]), 0);
    pulse_trig(0, 1);
    chk("R6", int'(q_dec[3:0]), 0);
    drv_clr[0] = 1'b0; step(4);
    pulse_trig(0, 1);
    chk("R6", int'(q_dec[3:0]), 1);
    chk("R9", int'(q_bin[7:4]), 2);

    // R10: ripple cascade
    cur_req = "R10";
    drv_gate[1] = 1'b0; step(6);            // gate fall, trigger low: 3
    ripple = 1'b1; step(6);
    pulse_trig(0, 9);
    chk("R10", int'(q_dec[7:4]), 4);
    chk("R10", int'(q_bin[7:4]), 3);
    pulse_trig(0, 6);
    chk("R10", int'(q_bin[7:4]), 4);
    chk("R10", int'(q_dec[7:4]), 4);
    step(4);
    summary();
  end
endmodule